// File: doc/BRIEF.md
# Shift-Mode SPI Master with Register Interface

This block is an SPI master driven entirely through a small memory-mapped register set. Software first opens register access with an enable bit, picks a clock divider and loads a transmit word. It then writes a shift command that carries a start bit, a chip-select mask, a terminate flag and a bit count. Hardware then clocks between 1 and 32 bits out on MOSI in SPI mode 0 and samples MISO into a receive register. The start bit reads back as a busy flag and clears itself when the last bit is done.

A frame can cover several shift commands. When a command is issued with the terminate flag clear, its chip select stays low after the last bit, so the next command continues the same frame. When no frame is open, the three chip selects, SCK and MOSI follow a pin-default register. That register resets to all chip selects high and SCK and MOSI low.

The shift engine is a three-state machine. In IDLE it waits for a command. The start transition IDLE->LOW loads the engine. LOW->HIGH happens on a half-period tick; SCK rises and MISO is sampled. HIGH->LOW happens on a half-period tick while bits remain; SCK falls and MOSI advances. HIGH->IDLE happens on a half-period tick after the last bit; SCK falls, the busy flag clears and the receive register is updated.

Top module: `spi_shift_master`

## Requirements
- R1: After reset, the pin-default register (byte offset 0x08) reads 0x00070000, the shift command register (0x14) reads 0, spi_cs_n is 3'b111, and spi_sck and spi_mosi are 0.
- R2: Writing the enable register (0x00) always takes effect, and its bit 0 reads back. While that bit is 0, writes to the divider (0x04), pin-default (0x08), transmit (0x10) and shift command (0x14) registers are ignored.
- R3: While no frame is open, spi_cs_n follows pin-default bits 18:16, spi_sck follows bit 8 and spi_mosi follows bit 0.
- R4: SCK idles low. During a shift, each half period of SCK lasts (div+1) system clocks, where div is bits 5:0 of register 0x04. The first rising edge comes one half period after the command is accepted.
- R5: Writing 1 to bit 31 of register 0x14 starts a shift. Bit 31 then reads 1 for exactly 2·N·(div+1) clocks and clears itself.
- R6: For an N-bit shift, transmit bit N-1 (register 0x10) is driven first, down to bit 0. MOSI changes only while SCK is low and holds its value across each rising edge.
- R7: MISO is sampled on each rising SCK edge. The receive register (0x18) is updated only when a shift completes, and then holds the N received bits right-aligned with the last bit in bit 0 and zeros above.
- R8: Bits 4:0 of the command give the bit count N; a value of 0 means 32.
- R9: During a frame, spi_cs_n is the inverse of command bits 30:28, so command bit 28+n drives chip select n low.
- R10: With command bit 26 set, the chip selects are released to the pin defaults after the last bit. With bit 26 clear, they stay asserted (and SCK low) until a later command with bit 26 set completes.
- R11: A write to register 0x14 while a shift is busy is ignored, including one in the same cycle the shift completes. The stored fields and the running transfer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 3 | Active-low chip selects |

## Verification
Two functions can meet in one clock edge: the completion of a running shift (the HIGH->IDLE transition, which clears busy and updates the receive register) and a new shift command written on the bus. The bench counts the clock edges from command acceptance and places a second command exactly on the completion edge. It judges the result through the bus and the pins. The late command must be dropped, the command register must still read the old fields with busy clear, and the chip selects must be released because the first command carried the terminate flag. A behavioural timeline model in the bench checks the pins on every clock throughout.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } shift_state_e;

    localparam logic [4:0] ADDR_ENABLE = 5'h00;
    localparam logic [4:0] ADDR_DIVIDE = 5'h04;
    localparam logic [4:0] ADDR_PINDEF = 5'h08;
    localparam logic [4:0] ADDR_TXWORD = 5'h10;
    localparam logic [4:0] ADDR_SHCMD  = 5'h14;
    localparam logic [4:0] ADDR_RXWORD = 5'h18;

    localparam int CMD_GO_BIT   = 31;
    localparam int CMD_CS_LSB   = 28;
    localparam int CMD_END_BIT  = 26;

    localparam int PIN_CS_LSB   = 16;
    localparam int PIN_SCK_BIT  = 8;
    localparam int PIN_MOSI_BIT = 0;

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q >= div);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/spi_shift_regs.sv
module spi_shift_regs
    import spi_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 6,
    parameter int NCS    = 3,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [4:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_sh,
    output logic [DATA_W-1:0] rdata,
    output logic [DIV_W-1:0]  div,
    output logic [NCS-1:0]    pin_cs,
    output logic              pin_sck,
    output logic              pin_mosi,
    output logic [DATA_W-1:0] txd,
    output logic [CNT_W-1:0]  nbits_fld,
    output logic [NCS-1:0]    sel,
    output logic              term,
    output logic              start
);
    logic              en_q;
    logic [DIV_W-1:0]  div_q;
    logic [NCS-1:0]    pcs_q;
    logic              psck_q, pmosi_q;
    logic [DATA_W-1:0] txd_q, rxd_q;
    logic [DATA_W-2:0] cmd_q;
    logic              wr_ok, cmd_wr;

    assign wr_ok  = we && en_q;
    assign cmd_wr = wr_ok && (addr == ADDR_SHCMD) && !busy;
    assign start  = cmd_wr && wdata[CMD_GO_BIT];

    assign nbits_fld = wdata[CNT_W-1:0];
    assign sel       = wdata[CMD_CS_LSB +: NCS];
    assign term      = wdata[CMD_END_BIT];

    assign div      = div_q;
    assign pin_cs   = pcs_q;
    assign pin_sck  = psck_q;
    assign pin_mosi = pmosi_q;
    assign txd      = txd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            div_q   <= '0;
            pcs_q   <= '1;
            psck_q  <= 1'b0;
            pmosi_q <= 1'b0;
            txd_q   <= '0;
            rxd_q   <= '0;
            cmd_q   <= '0;
        end else begin
            if (we && addr == ADDR_ENABLE)
                en_q <= wdata[0];
            if (wr_ok) begin
                case (addr)
                    ADDR_DIVIDE: div_q <= wdata[DIV_W-1:0];
                    ADDR_PINDEF: begin
                        pcs_q   <= wdata[PIN_CS_LSB +: NCS];
                        psck_q  <= wdata[PIN_SCK_BIT];
                        pmosi_q <= wdata[PIN_MOSI_BIT];
                    end
                    ADDR_TXWORD: txd_q <= wdata;
                    default: ;
                endcase
            end
            if (cmd_wr)
                cmd_q <= wdata[DATA_W-2:0];
            if (done)
                rxd_q <= rx_sh;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_ENABLE: rdata[0] = en_q;
            ADDR_DIVIDE: rdata[DIV_W-1:0] = div_q;
            ADDR_PINDEF: begin
                rdata[PIN_CS_LSB +: NCS] = pcs_q;
                rdata[PIN_SCK_BIT]       = psck_q;
                rdata[PIN_MOSI_BIT]      = pmosi_q;
            end
            ADDR_TXWORD: rdata = txd_q;
            ADDR_SHCMD:  rdata = {busy, cmd_q};
            ADDR_RXWORD: rdata = rxd_q;
            default:     rdata = '0;
        endcase
    end

    assert_rx_only_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(rxd_q));

    assert_busy_cmd_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && we && addr == ADDR_SHCMD) |=> $stable(cmd_q));

endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm
    import spi_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5,
    parameter int NCS    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  nbits_fld,
    input  logic [NCS-1:0]    sel_in,
    input  logic              term_in,
    input  logic [DATA_W-1:0] txd,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic              frame_act,
    output logic              sck,
    output logic              mosi,
    output logic [NCS-1:0]    cs_sel,
    output logic [DATA_W-1:0] rx_sh,
    output logic              restart
);
    localparam int BIT_W = $clog2(DATA_W + 1);

    shift_state_e      state_q, state_d;
    logic [DATA_W-1:0] tx_q, rx_q;
    logic [BIT_W-1:0]  left_q, nbits;
    logic [NCS-1:0]    sel_q;
    logic              term_q, frame_q, last;

    assign nbits = (nbits_fld == '0 || int'(nbits_fld) > DATA_W)
                   ? BIT_W'(DATA_W) : BIT_W'(nbits_fld);
    assign last  = (left_q == BIT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOW;
            ST_LOW:  if (tick)  state_d = ST_HIGH;
            ST_HIGH: if (tick)  state_d = last ? ST_IDLE : ST_LOW;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q    <= '0;
            rx_q    <= '0;
            left_q  <= '0;
            sel_q   <= '0;
            term_q  <= 1'b0;
            frame_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    tx_q    <= txd << (BIT_W'(DATA_W) - nbits);
                    rx_q    <= '0;
                    left_q  <= nbits;
                    sel_q   <= sel_in;
                    term_q  <= term_in;
                    frame_q <= 1'b1;
                end
                ST_LOW: if (tick)
                    rx_q <= {rx_q[DATA_W-2:0], miso};
                ST_HIGH: if (tick) begin
                    if (last)
                        frame_q <= !term_q;
                    else begin
                        tx_q   <= tx_q << 1;
                        left_q <= left_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy    = (state_q != ST_IDLE);
        sck     = (state_q == ST_HIGH);
        done    = (state_q == ST_HIGH) && tick && last;
        restart = (state_q == ST_IDLE);
    end

    assign mosi      = tx_q[DATA_W-1];
    assign frame_act = frame_q;
    assign cs_sel    = sel_q;
    assign rx_sh     = rx_q;

    assert_done_clears_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_busy_needs_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_sck_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(sck));

    assert_mosi_held_at_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(mosi));

    assert_release_on_term_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && term_q) |=> !frame_act);

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
    import spi_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 6,
    parameter int NCS    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [4:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NCS-1:0]    spi_cs_n
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [DIV_W-1:0]  div;
    logic [NCS-1:0]    pin_cs, sel, cs_sel;
    logic              pin_sck, pin_mosi, term, start;
    logic [DATA_W-1:0] txd, rx_sh;
    logic [CNT_W-1:0]  nbits_fld;
    logic              busy, done, frame_act, sck, mosi, restart, tick;

    spi_shift_regs #(
        .DATA_W(DATA_W), .DIV_W(DIV_W), .NCS(NCS), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .busy(busy), .done(done), .rx_sh(rx_sh),
        .rdata(bus_rdata), .div(div), .pin_cs(pin_cs), .pin_sck(pin_sck),
        .pin_mosi(pin_mosi), .txd(txd), .nbits_fld(nbits_fld), .sel(sel),
        .term(term), .start(start)
    );

    spi_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .restart(restart), .div(div), .tick(tick)
    );

    spi_shift_fsm #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .NCS(NCS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .nbits_fld(nbits_fld),
        .sel_in(sel), .term_in(term), .txd(txd), .tick(tick), .miso(spi_miso),
        .busy(busy), .done(done), .frame_act(frame_act), .sck(sck),
        .mosi(mosi), .cs_sel(cs_sel), .rx_sh(rx_sh), .restart(restart)
    );

    assign spi_cs_n = frame_act ? ~cs_sel : pin_cs;
    assign spi_sck  = frame_act ? sck     : pin_sck;
    assign spi_mosi = frame_act ? mosi    : pin_mosi;

endmodule

// File: tb/spi_shift_master_test.sv
module spi_shift_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        spi_miso = 1'b0;
    wire  [31:0] bus_rdata;
    wire         spi_sck, spi_mosi;
    wire  [2:0]  spi_cs_n;

    always #10 clk = ~clk;

    spi_shift_master uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    int errors = 0;
    int checks = 0;
    bit running = 1'b0;

    // behavioural model state
    bit          m_en, m_busy, m_hold, m_term;
    bit   [5:0]  m_div;
    bit   [2:0]  m_pcs, m_sel;
    bit          m_psck, m_pmosi;
    bit   [31:0] m_txd, m_tx, m_din, m_rxlat, rxpat;
    bit   [30:0] m_cmd;
    int          m_e, m_n, m_half;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(logic [4:0] a);
        logic [31:0] v = '0;
        case (a)
            5'h00: v[0] = m_en;
            5'h04: v[5:0] = m_div;
            5'h08: begin v[18:16] = m_pcs; v[8] = m_psck; v[0] = m_pmosi; end
            5'h10: v = m_txd;
            5'h14: v = {m_busy, m_cmd};
            5'h18: v = m_din;
            default: v = '0;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin : model
        bit en_old, go;
        logic [63:0] msk;
        go = 1'b0;
        if (!rst_n) begin
            m_en = 0; m_busy = 0; m_hold = 0; m_term = 0; m_div = 0;
            m_pcs = 3'b111; m_psck = 0; m_pmosi = 0; m_sel = 0;
            m_txd = 0; m_tx = 0; m_din = 0; m_cmd = 0; m_e = 0; m_n = 32; m_half = 1;
        end else begin
            en_old = m_en;
            if (bus_we) begin
                if (bus_addr == 5'h00) m_en = bus_wdata[0];
                else if (en_old) begin
                    case (bus_addr)
                        5'h04: m_div = bus_wdata[5:0];
                        5'h08: begin m_pcs = bus_wdata[18:16]; m_psck = bus_wdata[8]; m_pmosi = bus_wdata[0]; end
                        5'h10: m_txd = bus_wdata;
                        5'h14: if (!m_busy) begin
                            m_cmd = bus_wdata[30:0];
                            go = bus_wdata[31];
                        end
                        default: ;
                    endcase
                end
            end
            if (go) begin
                m_n = (bus_wdata[4:0] == 0) ? 32 : int'(bus_wdata[4:0]);
                m_half = int'(m_div) + 1;
                m_tx = m_txd; m_sel = bus_wdata[30:28]; m_term = bus_wdata[26];
                m_hold = 1; m_busy = 1; m_e = 0; m_rxlat = rxpat;
            end else if (m_busy) begin
                m_e++;
                if (m_e == 2 * m_n * m_half) begin
                    m_busy = 0;
                    msk = (64'd1 << m_n) - 64'd1;
                    m_din = m_rxlat & msk[31:0];
                    if (m_term) m_hold = 0;
                end
            end
        end
    end

    // per-cycle comparison of pins, then drive MISO for the coming half cycle
    always @(negedge clk) begin
        logic [2:0] e_cs;
        logic e_sck, e_mosi;
        if (running) begin
            if (m_hold) begin
                e_cs   = ~m_sel;
                e_sck  = m_busy && (((m_e / m_half) % 2) == 1);
                e_mosi = m_busy ? m_tx[m_n - 1 - m_e / (2 * m_half)] : m_tx[0];
            end else begin
                e_cs = m_pcs; e_sck = m_psck; e_mosi = m_pmosi;
            end
            chk("R9/R10 cs_n", {29'd0, spi_cs_n}, {29'd0, e_cs});
            chk("R4 sck", {31'd0, spi_sck}, {31'd0, e_sck});
            chk("R6 mosi", {31'd0, spi_mosi}, {31'd0, e_mosi});
        end
        spi_miso = m_busy ? m_rxlat[m_n - 1 - m_e / (2 * m_half)] : 1'b0;
    end

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdx(logic [4:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        chk({tag, " model"}, bus_rdata, model_read(a));
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rxpat = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 cs_n", {29'd0, spi_cs_n}, 32'd7);
        chk("R1 sck", {31'd0, spi_sck}, 32'd0);
        chk("R1 mosi", {31'd0, spi_mosi}, 32'd0);
        running = 1'b1;
        rdx(5'h08, 32'h0007_0000, "R1 pin default");
        rdx(5'h14, 32'h0, "R1 shift cmd");

        // R2 gating by the enable bit
        wr(5'h04, 32'd5);
        rdx(5'h04, 32'd0, "R2 divider gated");
        wr(5'h10, 32'hDEAD_BEEF);
        rdx(5'h10, 32'd0, "R2 txword gated");
        wr(5'h00, 32'd1);
        rdx(5'h00, 32'd1, "R2 enable readback");
        wr(5'h04, 32'd5);
        rdx(5'h04, 32'd5, "R2 divider open");

        // R3 pins follow defaults
        wr(5'h08, 32'h0005_0101);
        @(negedge clk); #1;
        chk("R3 cs_n", {29'd0, spi_cs_n}, 32'd5);
        chk("R3 sck", {31'd0, spi_sck}, 32'd1);
        chk("R3 mosi", {31'd0, spi_mosi}, 32'd1);
        wr(5'h08, 32'h0007_0000);

        // R5 R6 R7 8-bit, fastest clock, cs0, terminate
        wr(5'h04, 32'd0);
        wr(5'h10, 32'h0000_00A5);
        rxpat = 32'h0000_003C;
        wr(5'h14, 32'h8000_0000 | (32'd1 << 28) | (32'd1 << 26) | 32'd8);
        rdx(5'h14, 32'h8000_0000 | (32'd1 << 28) | (32'd1 << 26) | 32'd8, "R5 busy set");
        wait_idle();
        rdx(5'h18, 32'h0000_003C, "R7 rx word");
        rdx(5'h14, (32'd1 << 28) | (32'd1 << 26) | 32'd8, "R5 busy cleared");

        // R10 held frame across two commands on cs1
        wr(5'h04, 32'd2);
        wr(5'h10, 32'h0000_1234);
        rxpat = 32'h0000_BEEF;
        wr(5'h14, 32'h8000_0000 | (32'd2 << 28) | 32'd16);
        wait_idle();
        #1;
        chk("R10 cs held", {29'd0, spi_cs_n}, 32'd5);
        rdx(5'h18, 32'h0000_BEEF, "R7 rx 16-bit");
        wr(5'h10, 32'h0000_005A);
        rxpat = 32'h0000_0081;
        wr(5'h14, 32'h8000_0000 | (32'd2 << 28) | (32'd1 << 26) | 32'd8);
        wait_idle();
        #1;
        chk("R10 cs released", {29'd0, spi_cs_n}, 32'd7);
        rdx(5'h18, 32'h0000_0081, "R7 rx tail");

        // R8 count field 0 means 32 bits, cs2
        wr(5'h04, 32'd1);
        wr(5'h10, 32'hC3A5_0F96);
        rxpat = 32'h9E37_79B9;
        wr(5'h14, 32'h8000_0000 | (32'd4 << 28) | (32'd1 << 26));
        wait_idle();
        rdx(5'h18, 32'h9E37_79B9, "R8 count zero gives 32");

        // R11 command while busy is ignored
        wr(5'h04, 32'd3);
        wr(5'h10, 32'h0000_0077);
        rxpat = 32'h0000_0011;
        wr(5'h14, 32'h8000_0000 | (32'd1 << 28) | (32'd1 << 26) | 32'd8);
        wr(5'h14, 32'h8000_0000 | (32'd4 << 28) | 32'd5);
        rdx(5'h14, 32'h8000_0000 | (32'd1 << 28) | (32'd1 << 26) | 32'd8, "R11 busy write dropped");
        wait_idle();
        rdx(5'h18, 32'h0000_0011, "R11 transfer intact");

        // R11 command landing on the completion edge
        wr(5'h04, 32'd0);
        wr(5'h10, 32'h0000_00F0);
        rxpat = 32'h0000_0005;
        wr(5'h14, 32'h8000_0000 | (32'd1 << 28) | (32'd1 << 26) | 32'd8);
        repeat (14) @(negedge clk);
        wr(5'h14, 32'h8000_0000 | (32'd2 << 28) | (32'd1 << 26) | 32'd16);
        @(negedge clk); #1;
        chk("R11 collision cs", {29'd0, spi_cs_n}, 32'd7);
        rdx(5'h14, (32'd1 << 28) | (32'd1 << 26) | 32'd8, "R11 collision dropped");
        rdx(5'h18, 32'h0000_0005, "R7 collision rx");

        // R8 odd count of 13 bits
        wr(5'h04, 32'd1);
        wr(5'h10, 32'h0000_1ABC);
        rxpat = 32'hFFFF_0F0F;
        wr(5'h14, 32'h8000_0000 | (32'd1 << 28) | (32'd1 << 26) | 32'd13);
        wait_idle();
        rdx(5'h18, 32'h0000_0F0F, "R8 thirteen bits");

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule